// File: doc/BRIEF.md
# Synchronous Buck PWM Latch and Driver Interlock

This block is the clocked control core of a synchronous buck power stage. An oscillator pulse starts every switching period. It sets a PWM latch and holds the low-side switch on while the pulse lasts. When the pulse ends, the block hands over to the high-side switch. The high side stays on until the ramp comparator reports that the ramp has crossed the error level, or until a persistent overcurrent ends the on-time early. The next oscillator pulse then starts the cycle again.

The analog ramp, the error amplifier, the comparators and the gate drivers sit outside the block and reach it only as single-bit flags. Both drive requests are registered. A drive request is raised only when the opposite gate reports that it is low. Dead time therefore follows the real gate discharge and not a fixed delay. Overcurrent is qualified by a blanking count in clock cycles that restarts at every high-side turn-on.

Top module: `pwm_interlock_ctrl`

## Requirements
- R1: While `en_i` is low, both drive outputs are low from the next clock onward. The latch is cleared, so after `en_i` returns high the high side stays off until an oscillator pulse arrives, and the low side turns on.
- R2: In the clock after any cycle with `osc_pulse_i` high, `hs_drive_o` is low. A ramp or current-limit flag in the same cycle does not stop the pulse from setting the latch.
- R3: After the oscillator pulse ends with no reset pending, `ls_drive_o` drops at the first clock. `hs_drive_o` rises at the first clock at which `ls_gate_low_i` is seen high with `ls_drive_o` already low.
- R4: A high `ramp_trip_i` while the high side is on drives `hs_drive_o` low at the next clock. The high side stays off for the rest of the period even if the flag drops again.
- R5: If no reset flag asserts after the pulse, the high side stays on until the next oscillator pulse (maximum duty).
- R6: With `ramp_trip_i` held high permanently, the high side never turns on and the low side stays on in every cycle.
- R7: With the high side on, `ilim_trip_i` high for BLANK_CYCLES consecutive cycles or fewer has no effect. When it stays high for BLANK_CYCLES+1 consecutive cycles, the high side is off from the next clock until the next oscillator pulse.
- R8: `ilim_trip_i` is ignored while the high side is off. The persistence count starts from zero at each high-side turn-on, so every period is judged on its own.
- R9: `hs_drive_o` rises only after a cycle in which `ls_gate_low_i` was high and `ls_drive_o` was low. `ls_drive_o` rises only after a cycle in which `hs_gate_low_i` was high and `hs_drive_o` was low.
- R10: `hs_drive_o` and `ls_drive_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Controller enable |
| osc_pulse_i | input | 1 | Oscillator pulse; starts a switching period |
| ramp_trip_i | input | 1 | Ramp above error level comparator flag |
| ilim_trip_i | input | 1 | Current-limit comparator flag |
| hs_gate_low_i | input | 1 | High-side gate is discharged |
| ls_gate_low_i | input | 1 | Low-side gate is discharged |
| hs_drive_o | output | 1 | High-side drive request |
| ls_drive_o | output | 1 | Low-side drive request |

## Verification
The hardest state to reach is the one where the current-limit flag has stayed high for exactly the blanking length, or one cycle more, counted from the real high-side turn-on. That turn-on itself moves with the gate feedback. The bench closes the loop with a behavioural gate model that reports a gate low two cycles after its request drops. It then sweeps pulse width, ramp-trip position, ramp pulses, and current-limit start points and lengths over a 16-cycle period. The expected on-time of each period is computed from the turn-on cycle and the earliest terminating event.

// File: rtl/pwmi_pkg.sv
package pwmi_pkg;

  // Which switch the latch currently asks for.
  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_LOW  = 2'd1,
    SIDE_HIGH = 2'd2
  } side_e;

  // Saturating increment of a persistence counter.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // True once the flag has persisted through the whole blanking window.
  function automatic logic blank_spent(input int unsigned run, input int unsigned lim);
    return run >= lim;
  endfunction

  // Requested side from the enable and the high-side wish.
  function automatic side_e pick_side(input logic en, input logic hs_want);
    if (!en)     return SIDE_NONE;
    if (hs_want) return SIDE_HIGH;
    return SIDE_LOW;
  endfunction

endpackage

// File: rtl/pwmi_latch.sv
module pwmi_latch
  import pwmi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  osc,
  input  logic  ramp,
  input  logic  kill,
  output logic  latch_q,
  output logic  hs_want,
  output side_e side
);

  // Set dominates during the oscillator pulse; otherwise any reset clears.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           latch_q <= 1'b0;
    else if (!en)         latch_q <= 1'b0;
    else if (osc)         latch_q <= 1'b1;
    else if (ramp | kill) latch_q <= 1'b0;
  end

  // Pulse and reset flags gate the high side immediately.
  always_comb begin
    hs_want = en & latch_q & ~osc & ~ramp & ~kill;
    side    = pick_side(en, hs_want);
  end

endmodule

// File: rtl/pwmi_blanker.sv
module pwmi_blanker
  import pwmi_pkg::*;
#(
  parameter int unsigned BLANK_CYCLES = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               hs_on,
  input  logic               ilim,
  output logic               kill,
  output logic [$clog2(BLANK_CYCLES+1):0] run_cnt
);

  localparam int CNT_W = $clog2(BLANK_CYCLES + 1) + 1;

  logic counting;
  assign counting = en & hs_on & ilim;

  // Consecutive high cycles of the limit flag while the high side is on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_cnt <= '0;
    else if (counting) run_cnt <= CNT_W'(sat_inc(int'(run_cnt), BLANK_CYCLES));
    else               run_cnt <= '0;
  end

  assign kill = counting & blank_spent(int'(run_cnt), BLANK_CYCLES);

endmodule

// File: rtl/pwmi_interlock.sv
module pwmi_interlock
  import pwmi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  side_e side,
  input  logic  hs_gl,
  input  logic  ls_gl,
  output logic  hs_q,
  output logic  ls_q
);

  logic hs_next, ls_next;

  // A side turns on only when the other request is off and its gate is low.
  always_comb begin
    hs_next = (side == SIDE_HIGH) & ls_gl & ~ls_q;
    ls_next = (side == SIDE_LOW)  & hs_gl & ~hs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      hs_q <= hs_next;
      ls_q <= ls_next;
    end
  end

endmodule

// File: rtl/pwm_interlock_ctrl.sv
module pwm_interlock_ctrl
  import pwmi_pkg::*;
#(
  parameter int unsigned BLANK_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic osc_pulse_i,
  input  logic ramp_trip_i,
  input  logic ilim_trip_i,
  input  logic hs_gate_low_i,
  input  logic ls_gate_low_i,
  output logic hs_drive_o,
  output logic ls_drive_o
);

  localparam int CNT_W = $clog2(BLANK_CYCLES + 1) + 1;

  // Named internal events, visible to the bound checker.
  logic             latch_q;
  logic             hs_want;
  side_e            side;
  logic             ilim_kill;
  logic [CNT_W-1:0] blank_cnt;
  logic             hs_q, ls_q;

  pwmi_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en_i),
    .osc     (osc_pulse_i),
    .ramp    (ramp_trip_i),
    .kill    (ilim_kill),
    .latch_q (latch_q),
    .hs_want (hs_want),
    .side    (side)
  );

  pwmi_blanker #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en_i),
    .hs_on   (hs_q),
    .ilim    (ilim_trip_i),
    .kill    (ilim_kill),
    .run_cnt (blank_cnt)
  );

  pwmi_interlock u_ilock (
    .clk   (clk),
    .rst_n (rst_n),
    .side  (side),
    .hs_gl (hs_gate_low_i),
    .ls_gl (ls_gate_low_i),
    .hs_q  (hs_q),
    .ls_q  (ls_q)
  );

  assign hs_drive_o = hs_q;
  assign ls_drive_o = ls_q;

endmodule

// File: rtl/pwmi_checker.sv
module pwmi_checker (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic osc_pulse_i,
  input logic ramp_trip_i,
  input logic hs_gate_low_i,
  input logic ls_gate_low_i,
  input logic hs_drive_o,
  input logic ls_drive_o,
  input logic ilim_kill,
  input logic latch_q
);

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_drive_o && ls_drive_o)); // R10

  AST_HS_WAITS_LS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_drive_o) |-> ($past(ls_gate_low_i) && !$past(ls_drive_o))); // R9

  AST_LS_WAITS_HS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_drive_o) |-> ($past(hs_gate_low_i) && !$past(hs_drive_o))); // R9

  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!hs_drive_o && !ls_drive_o && !latch_q)); // R1

  AST_OSC_BLOCKS_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && osc_pulse_i) |=> (!hs_drive_o && latch_q)); // R2

  AST_HS_RISE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_drive_o) |-> !$past(osc_pulse_i)); // R3

  AST_RAMP_ENDS_HS: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_trip_i |=> !hs_drive_o); // R4

  AST_ILIM_ENDS_HS: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_kill |=> !hs_drive_o); // R7

  AST_KILL_ONLY_HS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_kill |-> hs_drive_o); // R8

endmodule

bind pwm_interlock_ctrl pwmi_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .en_i          (en_i),
  .osc_pulse_i   (osc_pulse_i),
  .ramp_trip_i   (ramp_trip_i),
  .hs_gate_low_i (hs_gate_low_i),
  .ls_gate_low_i (ls_gate_low_i),
  .hs_drive_o    (hs_drive_o),
  .ls_drive_o    (ls_drive_o),
  .ilim_kill     (ilim_kill),
  .latch_q       (latch_q)
);

// File: tb/test_pwm_interlock_ctrl.sv
module test_pwm_interlock_ctrl;

  localparam int B = 3;   // blanking cycles for the bench configuration
  localparam int P = 16;  // switching period in cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, osc = 1'b0, ramp = 1'b0, ilim = 1'b0;
  logic force_ls_busy = 1'b0;
  logic [1:0] hs_hist = 2'b00, ls_hist = 2'b00;
  logic hs_gl, ls_gl, hs_d, ls_d;
  int checks = 0, errors = 0, overlaps = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // Gate model: a gate reads low once its request has been low for two samples.
  assign hs_gl = ~(|hs_hist);
  assign ls_gl = ~(|ls_hist) & ~force_ls_busy;

  pwm_interlock_ctrl #(.BLANK_CYCLES(B)) i_pwm_interlock_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (en),
    .osc_pulse_i   (osc),
    .ramp_trip_i   (ramp),
    .ilim_trip_i   (ilim),
    .hs_gate_low_i (hs_gl),
    .ls_gate_low_i (ls_gl),
    .hs_drive_o    (hs_d),
    .ls_drive_o    (ls_d)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: sample after the edge, then advance the gate model.
  task automatic step();
    @(posedge clk);
    #1;
    hs_hist = {hs_hist[0], hs_d};
    ls_hist = {ls_hist[0], ls_d};
    if (hs_d && ls_d) overlaps++;
  endtask

  task automatic run_period(input int w, input int r, input bit rp, input int s, input int se,
                            output int hc, output int hf, output int lc, output int hp);
    hc = 0; hf = -1; lc = 0; hp = 0;
    for (int t = 0; t < P; t++) begin
      osc  = (t < w);
      ramp = (t >= r) && (!rp || t < r + 2);
      ilim = (t >= s) && (t < se);
      step();
      if (hs_d) begin
        if (hf < 0) hf = t;
        hc++;
        if (t < w) hp++;
      end
      if (ls_d) lc++;
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hc, hf, lc, hp;
    int r, s, se, reff, seff, kill_t, endc, expc;
    string tag;

    // Reset state
    repeat (3) step();
    check("R1 reset hs", int'(hs_d), 0);
    check("R1 reset ls", int'(ls_d), 0);
    rst_n = 1'b1;
    en = 1'b1;
    repeat (3) step();

    // Sweep over pulse width, ramp position, ramp pulses, current-limit patterns
    for (int w = 3; w <= 4; w++) begin
      for (int ri = 0; ri <= P - w + 1; ri++) begin
        r = (ri == 0) ? 0 : w + ri - 1;
        for (int rp = 0; rp <= 1; rp++) begin
          for (int im = 0; im <= P - w + 2; im++) begin
            if (im == 0)      begin s = P;      se = P;         end
            else if (im == 1) begin s = 0;      se = w;         end
            else if (im == 2) begin s = w + 3;  se = w + 3 + B; end
            else              begin s = w + im - 3; se = P;     end
            run_period(w, r, rp[0], s, se, hc, hf, lc, hp);
            run_period(w, r, rp[0], s, se, hc, hf, lc, hp);
            reff   = (rp != 0) ? ((r < w) ? P : r) : r;
            seff   = (s > w + 3) ? s : w + 3;
            kill_t = (se - seff > B) ? seff + B : P;
            endc   = reff;
            if (kill_t < endc) endc = kill_t;
            if (P < endc) endc = P;
            expc   = (endc - w - 2 > 0) ? endc - w - 2 : 0;
            if (r == 0 && rp == 0)              tag = "R6";
            else if (kill_t < reff && kill_t < P) tag = "R7";
            else if (im == 2)                   tag = "R7 short";
            else if (im == 1)                   tag = "R8";
            else if (reff == P)                 tag = "R5";
            else                                tag = "R4";
            check($sformatf("%s hs on-time w=%0d r=%0d rp=%0d im=%0d", tag, w, r, rp, im), hc, expc);
            if (expc > 0)
              check($sformatf("R3 hs turn-on cycle w=%0d r=%0d", w, r), hf, w + 2);
            if (r == 0 && rp == 0)
              check("R6 ls every cycle", lc, P);
            if (im == 0)
              check("R2 hs during pulse", hp, 0);
          end
        end
      end
    end

    // Enable: drop while high side is on, then recover without a pulse
    ramp = 1'b0; ilim = 1'b0;
    for (int t = 0; t < 9; t++) begin
      osc = (t < 3);
      step();
    end
    check("R5 hs on before disable", int'(hs_d), 1);
    en = 1'b0;
    step();
    check("R1 disable hs", int'(hs_d), 0);
    check("R1 disable ls", int'(ls_d), 0);
    step();
    en = 1'b1;
    hc = 0;
    for (int t = 0; t < 6; t++) begin
      step();
      if (hs_d) hc++;
    end
    check("R1 latch cleared hs", hc, 0);
    check("R1 ls after enable", int'(ls_d), 1);
    run_period(3, P, 1'b0, P, P, hc, hf, lc, hp);
    check("R1 recovery period", hc, P - 5);

    // Interlock: low-side gate never reports low
    force_ls_busy = 1'b1;
    run_period(3, P, 1'b0, P, P, hc, hf, lc, hp);
    check("R9 hs blocked by ls gate", hc, 0);
    force_ls_busy = 1'b0;
    run_period(3, P, 1'b0, P, P, hc, hf, lc, hp);
    run_period(3, P, 1'b0, P, P, hc, hf, lc, hp);
    check("R9 hs after release", hc, P - 5);

    check("R10 overlap cycles", overlaps, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule